// File: doc/BRIEF.md
# Endian-Aware Multi-Register Bus Lane Steering

This block sits between a DSP core's register file and a 64-bit memory data bus. On a multi-register move it decides which bus lane each register element uses, based on the endian mode, and it does the same job in reverse when data comes back from memory. It moves whole 16-bit or 32-bit elements and never swaps bytes. As a result, each register's value sits at the same memory address whether the core runs big-endian or little-endian.

A request carries five things: a valid strobe, a direction flag, an endian flag, a two-bit access kind, and either the packed register operands (on a write) or the bus word (on a read). The block registers each request, so the steered result appears one cycle later together with a valid pulse. A write also produces a byte-enable mask. An access-kind code that is not defined raises an error pulse instead of a valid.

Register operands are packed with element 0 in the least significant position. For 16-bit elements, element k occupies bits [16k+15:16k]. For 32-bit elements, element k occupies bits [32k+31:32k]. Bus lanes are counted the same way, with the lowest lane at the least significant end.

Top module: `mrx_lane_steer`

## Requirements
- R1: While reset is high, and on the cycle after it, `wr_valid_o`, `rd_valid_o` and `kind_err_o` are 0, and `bus_wdata_o`, `bus_be_o` and `reg_rdata_o` are all zero.
- R2: Access kind 2'b00 (two 16-bit elements) uses only bus bits [31:0]. Big-endian puts element 0 in bits [31:16] and element 1 in bits [15:0]. Little-endian puts element 0 in bits [15:0] and element 1 in bits [31:16]. Bits [63:32] of the written data are 0, and `bus_be_o` is 8'h0F.
- R3: Access kind 2'b01 (four 16-bit elements) fills the whole bus. Big-endian puts element k in 16-bit lane 3-k. Little-endian puts element k in lane k. `bus_be_o` is 8'hFF.
- R4: Access kind 2'b10 (two 32-bit elements) fills the whole bus. Big-endian puts element 0 in bits [63:32]. Little-endian puts element 0 in bits [31:0]. `bus_be_o` is 8'hFF.
- R5: The contents of every element, including its byte order, reach their destination unchanged in both modes. Only the position of the element changes.
- R6: A read applies the same lane mapping in reverse. Register element k takes the bus lane that a write of the same kind and mode would have filled from element k.
- R7: On a read of kind 2'b00, `reg_rdata_o` bits [63:32] are 0, whatever is on bus bits [63:32].
- R8: An accepted request produces exactly one valid pulse, one cycle later. A write request pulses `wr_valid_o` and a read request pulses `rd_valid_o`. Both are 0 in a cycle that follows no accepted request.
- R9: A request of kind 2'b11 pulses `kind_err_o` one cycle later. It pulses neither valid, and it leaves `bus_wdata_o`, `bus_be_o` and `reg_rdata_o` unchanged.
- R10: The endian flag is captured with each request. A change of the flag in the following cycle does not affect that request's result.
- R11: `bus_wdata_o` and `bus_be_o` change only after an accepted write. `reg_rdata_o` changes only after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write toward memory, 0 = read from memory |
| req_little_i | input | 1 | 1 = little-endian, 0 = big-endian |
| req_kind_i | input | 2 | Access kind: 00 two words, 01 four words, 10 two longwords, 11 illegal |
| reg_wdata_i | input | 64 | Packed register operands for a write |
| bus_rdata_i | input | 64 | Bus data for a read |
| bus_wdata_o | output | 64 | Steered bus data for a write |
| bus_be_o | output | 8 | Byte enables of the written data |
| wr_valid_o | output | 1 | Write result valid |
| reg_rdata_o | output | 64 | Packed register values from a read |
| rd_valid_o | output | 1 | Read result valid |
| kind_err_o | output | 1 | Illegal access kind seen |

## Verification
A wrong lane route shows at the ports on the cycle right after the request. The affected 16-bit lane holds a neighbouring element or the wrong half of a longword. A wrong byte order inside an element shows as a swapped halfword in the same cycle. A stale or wrongly enabled capture register shows as output data that changes when a read, an idle cycle or an illegal request goes by. Write-then-read round trips over every kind and mode, with varied data, expose a broken inverse mapping on the read path within one extra cycle.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [1:0] {
    K_W16X2 = 2'b00,
    K_W16X4 = 2'b01,
    K_W32X2 = 2'b10,
    K_BAD   = 2'b11
  } kind_e;

  // number of 16-bit lanes one element spans
  function automatic int elem_span(kind_e k);
    return (k == K_W32X2) ? 2 : 1;
  endfunction

  // number of elements moved by one access
  function automatic int elem_count(kind_e k);
    case (k)
      K_W16X4: return 4;
      K_BAD:   return 0;
      default: return 2;
    endcase
  endfunction

  // lanes covered by an access
  function automatic int active_lanes(kind_e k);
    return elem_span(k) * elem_count(k);
  endfunction

  // Source lane for destination lane dst, or -1 when dst is unused.
  // Big-endian reverses the element order; little-endian keeps it.
  // The element permutation is its own inverse, so the same route
  // serves registers->bus and bus->registers.
  function automatic int lane_src(kind_e k, logic little, int dst);
    int span;
    int cnt;
    int slot;
    int part;
    int other;
    span = elem_span(k);
    cnt  = elem_count(k);
    slot = dst / span;
    part = dst % span;
    if (slot >= cnt) return -1;
    other = little ? slot : (cnt - 1 - slot);
    return other * span + part;
  endfunction

endpackage

// File: rtl/mrx_req_decode.sv
module mrx_req_decode
  import mrx_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int BYTES = LANES * LANE_W / 8
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  kind_e            kind,
  output logic             acc_wr,
  output logic             acc_rd,
  output logic             acc_bad,
  output logic [BYTES-1:0] be
);

  localparam int LANE_BYTES = LANE_W / 8;

  logic legal;

  assign legal   = (kind != K_BAD);
  assign acc_wr  = req_valid & req_write & legal;
  assign acc_rd  = req_valid & ~req_write & legal;
  assign acc_bad = req_valid & ~legal;

  always_comb begin
    int lim;
    lim = active_lanes(kind) * LANE_BYTES;
    for (int b = 0; b < BYTES; b++) begin
      be[b] = (b < lim);
    end
  end

endmodule

// File: rtl/mrx_lane_xbar.sv
module mrx_lane_xbar
  import mrx_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  kind_e             kind,
  input  logic              little,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    int src;
    assign src = lane_src(kind, little, j);
    always_comb begin
      dout[j*LANE_W +: LANE_W] = '0;
      for (int c = 0; c < LANES; c++) begin
        if (src == c) dout[j*LANE_W +: LANE_W] = din[c*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/mrx_out_stage.sv
module mrx_out_stage #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic              acc_bad,
  input  logic [DATA_W-1:0] wr_next,
  input  logic [BYTES-1:0]  be_next,
  input  logic [DATA_W-1:0] rd_next,
  output logic [DATA_W-1:0] wr_q,
  output logic [BYTES-1:0]  be_q,
  output logic              wr_vld_q,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_vld_q,
  output logic              err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= '0;
      be_q     <= '0;
      wr_vld_q <= 1'b0;
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      wr_vld_q <= acc_wr;
      rd_vld_q <= acc_rd;
      err_q    <= acc_bad;
      if (acc_wr) begin
        wr_q <= wr_next;
        be_q <= be_next;
      end
      if (acc_rd) rd_q <= rd_next;
    end
  end

endmodule

// File: rtl/mrx_lane_steer.sv
module mrx_lane_steer
  import mrx_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES,
  localparam int BYTES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_little_i,
  input  logic [1:0]        req_kind_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [BYTES-1:0]  bus_be_o,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rd_valid_o,
  output logic              kind_err_o
);

  kind_e             kind;
  logic              acc_wr;
  logic              acc_rd;
  logic              acc_bad;
  logic [BYTES-1:0]  be_next;
  logic [DATA_W-1:0] wr_steered;
  logic [DATA_W-1:0] rd_steered;

  assign kind = kind_e'(req_kind_i);

  mrx_req_decode #(.LANE_W(LANE_W), .LANES(LANES)) dec_i (
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .kind      (kind),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_bad   (acc_bad),
    .be        (be_next)
  );

  mrx_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) pack_i (
    .kind   (kind),
    .little (req_little_i),
    .din    (reg_wdata_i),
    .dout   (wr_steered)
  );

  mrx_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) unpack_i (
    .kind   (kind),
    .little (req_little_i),
    .din    (bus_rdata_i),
    .dout   (rd_steered)
  );

  mrx_out_stage #(.DATA_W(DATA_W)) out_i (
    .clk      (clk),
    .rst      (rst),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .acc_bad  (acc_bad),
    .wr_next  (wr_steered),
    .be_next  (be_next),
    .rd_next  (rd_steered),
    .wr_q     (bus_wdata_o),
    .be_q     (bus_be_o),
    .wr_vld_q (wr_valid_o),
    .rd_q     (reg_rdata_o),
    .rd_vld_q (rd_valid_o),
    .err_q    (kind_err_o)
  );

endmodule

// File: rtl/mrx_lane_steer_chk.sv
module mrx_lane_steer_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic        req_little_i,
  input logic [1:0]  req_kind_i,
  input logic [63:0] reg_wdata_i,
  input logic [63:0] bus_wdata_o,
  input logic [7:0]  bus_be_o,
  input logic        wr_valid_o,
  input logic [63:0] reg_rdata_o,
  input logic        rd_valid_o,
  input logic        kind_err_o,
  input logic        acc_wr,
  input logic        acc_rd
);

  a_r8_write_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_write_i && req_kind_i != 2'b11 |=> wr_valid_o && !rd_valid_o);

  a_r8_read_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && !req_write_i && req_kind_i != 2'b11 |=> rd_valid_o && !wr_valid_o);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !wr_valid_o && !rd_valid_o && !kind_err_o);

  a_r9_illegal_kind: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_kind_i == 2'b11 |=> kind_err_o && !wr_valid_o && !rd_valid_o);

  a_r2_upper_idle: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_write_i && req_kind_i == 2'b00 |=>
      bus_be_o == 8'h0F && bus_wdata_o[63:32] == 32'h0);

  a_r3_be_word0: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_write_i && req_kind_i == 2'b01 && !req_little_i |=>
      bus_be_o == 8'hFF && bus_wdata_o[63:48] == $past(reg_wdata_i[15:0]));

  a_r4_le_long0: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_write_i && req_kind_i == 2'b10 && req_little_i |=>
      bus_wdata_o[31:0] == $past(reg_wdata_i[31:0]));

  a_r11_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(bus_wdata_o) && $stable(bus_be_o));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(reg_rdata_o));

endmodule

bind mrx_lane_steer mrx_lane_steer_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .req_little_i (req_little_i),
  .req_kind_i   (req_kind_i),
  .reg_wdata_i  (reg_wdata_i),
  .bus_wdata_o  (bus_wdata_o),
  .bus_be_o     (bus_be_o),
  .wr_valid_o   (wr_valid_o),
  .reg_rdata_o  (reg_rdata_o),
  .rd_valid_o   (rd_valid_o),
  .kind_err_o   (kind_err_o),
  .acc_wr       (acc_wr),
  .acc_rd       (acc_rd)
);

// File: tb/mrx_lane_steer_tb.sv
module mrx_lane_steer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic        req_little_i = 1'b0;
  logic [1:0]  req_kind_i = 2'b00;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] bus_rdata_i = '0;
  logic [63:0] bus_wdata_o;
  logic [7:0]  bus_be_o;
  logic        wr_valid_o;
  logic [63:0] reg_rdata_o;
  logic        rd_valid_o;
  logic        kind_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mrx_lane_steer dut_i (
    .clk, .rst, .req_valid_i, .req_write_i, .req_little_i, .req_kind_i,
    .reg_wdata_i, .bus_rdata_i, .bus_wdata_o, .bus_be_o, .wr_valid_o,
    .reg_rdata_o, .rd_valid_o, .kind_err_o
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // element width and count computed from the kind code
  function automatic int ew(int k); return (k == 2) ? 32 : 16; endfunction
  function automatic int en(int k); return (k == 1) ? 4 : 2; endfunction

  function automatic logic [63:0] model_bus(int k, bit le, logic [63:0] regs);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < en(k); i++) begin
      int pos;
      pos = le ? i : en(k) - 1 - i;
      for (int b = 0; b < ew(k); b++) e[pos*ew(k)+b] = regs[i*ew(k)+b];
    end
    return e;
  endfunction

  function automatic logic [63:0] model_regs(int k, bit le, logic [63:0] bus);
    logic [63:0] e;
    e = '0;
    for (int i = 0; i < en(k); i++) begin
      int pos;
      pos = le ? i : en(k) - 1 - i;
      for (int b = 0; b < ew(k); b++) e[i*ew(k)+b] = bus[pos*ew(k)+b];
    end
    return e;
  endfunction

  task automatic drive(bit v, bit w, bit le, logic [1:0] k, logic [63:0] r, logic [63:0] b);
    @(negedge clk);
    req_valid_i = v; req_write_i = w; req_little_i = le;
    req_kind_i = k; reg_wdata_i = r; bus_rdata_i = b;
  endtask

  task automatic one_write(logic [1:0] k, bit le, logic [63:0] r, string tag);
    drive(1, 1, le, k, r, '0);
    drive(0, 0, ~le, k, '0, '0);
    chk({tag, " wdata"}, bus_wdata_o, model_bus(int'(k), le, r));
    chk({tag, " be"}, {56'h0, bus_be_o}, (k == 2'b00) ? 64'h0F : 64'hFF);
    chk("R8 wr_valid", {63'h0, wr_valid_o}, 64'h1);
  endtask

  initial begin
    logic [63:0] seed;
    logic [63:0] last_w;
    logic [7:0]  last_be;
    logic [63:0] last_r;
    seed = 64'h0123_4567_89AB_CDEF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset wdata", bus_wdata_o, '0);
    chk("R1 reset rdata", reg_rdata_o, '0);
    chk("R1 reset flags", {56'h0, bus_be_o, wr_valid_o, rd_valid_o, kind_err_o} >> 3, '0);
    chk("R1 reset valids", {61'h0, wr_valid_o, rd_valid_o, kind_err_o}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {61'h0, wr_valid_o, rd_valid_o, kind_err_o}, '0);

    // fixed vectors with literal expectations (R2, R3, R4, R5)
    one_write(2'b00, 0, 64'h0304_0102, "R2 be2w");
    chk("R2 literal BE", bus_wdata_o, 64'h0000_0000_0102_0304);
    one_write(2'b00, 1, 64'h0304_0102, "R2 le2w");
    chk("R2 literal LE", bus_wdata_o, 64'h0000_0000_0304_0102);
    one_write(2'b01, 0, 64'h0708_0506_0304_0102, "R3 be4w");
    chk("R3 literal BE", bus_wdata_o, 64'h0102_0304_0506_0708);
    one_write(2'b01, 1, 64'h0708_0506_0304_0102, "R3 le4w");
    chk("R5 literal LE", bus_wdata_o, 64'h0708_0506_0304_0102);
    one_write(2'b10, 0, 64'hccdd_eeff_1122_3344, "R4 be2l");
    chk("R4 literal BE", bus_wdata_o, 64'h1122_3344_ccdd_eeff);
    one_write(2'b10, 1, 64'hccdd_eeff_1122_3344, "R4 le2l");
    chk("R4 literal LE", bus_wdata_o, 64'hccdd_eeff_1122_3344);

    // sweep: every kind, both modes, varied data (R2..R8, R11)
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 12; p++) begin
          logic [63:0] rv;
          logic [63:0] bv;
          seed = seed * 64'h5851_F42D_4C95_7F2D + 64'h1;
          rv = seed;
          seed = seed * 64'h5851_F42D_4C95_7F2D + 64'h1;
          bv = (p == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : seed;
          one_write(2'(k), m[0], rv, "R5 sweep");
          last_w = bus_wdata_o;
          last_be = bus_be_o;
          drive(1, 0, m[0], 2'(k), ~rv, bv);
          drive(0, 0, m[0], 2'(k), '0, '0);
          chk("R6 rdata", reg_rdata_o, model_regs(k, m[0], bv));
          chk("R8 rd_valid", {62'h0, rd_valid_o, wr_valid_o}, 64'h2);
          chk("R11 wdata held over read", bus_wdata_o, last_w);
          chk("R11 be held over read", {56'h0, bus_be_o}, {56'h0, last_be});
          if (k == 0) chk("R7 upper regs zero", reg_rdata_o & 64'hFFFF_FFFF_0000_0000, '0);
          // round trip: reading back the written bus restores registers
          drive(1, 0, m[0], 2'(k), '0, last_w);
          drive(0, 0, m[0], 2'(k), '0, '0);
          chk("R6 round trip", reg_rdata_o, model_bus(0, 1, rv) == 0 ? '0 :
              ((k == 1 || k == 2) ? rv : (rv & 64'h0000_0000_FFFF_FFFF)));
          drive(0, 0, m[0], 2'(k), '0, '0);
          chk("R8 idle valids", {62'h0, wr_valid_o, rd_valid_o}, '0);
        end
      end
    end

    // R10: back-to-back writes with the mode flipped between them
    drive(1, 1, 1, 2'b01, 64'h0708_0506_0304_0102, '0);
    drive(1, 1, 0, 2'b01, 64'h0708_0506_0304_0102, '0);
    chk("R10 first keeps LE", bus_wdata_o, 64'h0708_0506_0304_0102);
    drive(0, 0, 1, 2'b01, '0, '0);
    chk("R10 second uses BE", bus_wdata_o, 64'h0102_0304_0506_0708);

    // R9: illegal kind, write and read
    last_w = bus_wdata_o;
    last_be = bus_be_o;
    last_r = reg_rdata_o;
    drive(1, 1, 0, 2'b11, 64'hDEAD_BEEF_CAFE_F00D, '0);
    drive(1, 0, 1, 2'b11, '0, 64'h1234_5678_9ABC_DEF0);
    chk("R9 err on write", {61'h0, kind_err_o, wr_valid_o, rd_valid_o}, 64'h4);
    chk("R9 wdata kept", bus_wdata_o, last_w);
    chk("R9 be kept", {56'h0, bus_be_o}, {56'h0, last_be});
    drive(0, 0, 0, 2'b00, '0, '0);
    chk("R9 err on read", {61'h0, kind_err_o, wr_valid_o, rd_valid_o}, 64'h4);
    chk("R9 rdata kept", reg_rdata_o, last_r);
    drive(0, 0, 0, 2'b00, '0, '0);
    chk("R9 err single pulse", {63'h0, kind_err_o}, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule